// File: doc/BRIEF.md
# Stall-Tolerant FPU Result Bypass and Interlock

This block sits between a short floating-point execute pipeline and the operand-read point of a later instruction that copies an FPU register to the integer side. Every instruction enters at the read stage (called R1 here). It then moves through four tracked slots: R2, E1, E2 and E3. It leaves at the end of E3, where a producer writes the register file and a move hands its value out. A move latches its source value at the moment it leaves R1 for R2. At that moment the block looks through the older in-flight slots and takes the youngest producer aimed at the same register. When no such producer exists, it reads the register file.

Short producers have their result ready on entry to E2. Long producers have it ready only on entry to E3. When the youngest matching producer has no result yet, the move is held in R1 and a bubble goes into R2. A global stall freezes every slot. Because forwarding reads the slot contents directly, a producer frozen in E3 still supplies its product once the stall lifts. A conservative mode delays every short result to E3, as if it were long. The arithmetic is a registered placeholder, `5*a + 0x9E37`, computed modulo 2^32.

Top module: `fpu_fwd_unit`

## Requirements
- R1: After reset, `issue_ready_o` is 1 while nothing is offered and there is no stall, `mv_valid_o` is 0, and every register reads as 0.
- R2: A move is accepted in a cycle where `issue_valid_i` and `issue_ready_o` are both 1. The value it latches at that point is later presented once on `mv_data_o` with `mv_valid_o` high, and moves come out in program order.
- R3: When several older in-flight producers target the move's register, the youngest one supplies the value. With no such producer, the register file supplies it.
- R4: With no stall and normal mode, a move directly after a short producer to its register waits 2 cycles. After a long producer it waits 3 cycles. With one unrelated instruction in between, a move after a short producer waits 1 cycle.
- R5: While `stall_i` is 1, nothing is accepted, no slot advances, nothing retires and the register file is not written. A move waiting on a long producer frozen in E3 receives that producer's result once the stall ends.
- R6: With `safe_mode_i` at 1, a move directly after a short producer waits 3 cycles. With three unrelated instructions in between, it does not wait.
- R7: A move whose register matches no in-flight producer is accepted without waiting.
- R8: `issue_op_i` encodes 0 as no-op, 1 as a short producer, 2 as a long producer and 3 as a move. A producer writes `5*issue_opnd_i + 0x9E37` (mod 2^32) to register `issue_idx_i`. A move reads register `issue_idx_i`.
- R9: Under random stalls and random instruction streams, in both modes, every move value equals that of a sequential register model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Global pipeline freeze |
| safe_mode_i | input | 1 | 1: short results become ready only in E3 |
| issue_valid_i | input | 1 | An instruction is offered in R1 |
| issue_op_i | input | 2 | Instruction kind (see R8) |
| issue_idx_i | input | 3 | Destination register (producer) or source register (move) |
| issue_opnd_i | input | 32 | Producer operand |
| issue_ready_o | output | 1 | The offered instruction advances to R2 this cycle |
| mv_valid_o | output | 1 | A move retires this cycle |
| mv_data_o | output | 32 | Value of the retiring move |

## Verification
The bench builds the block with the package defaults: eight 32-bit registers and four tracked slots. With only eight registers, random streams keep hitting back-to-back dependencies, several producers aimed at one register, and stalls landing while a producer sits in E3. The full 32-bit operand range lets the placeholder arithmetic wrap, so a stale value and a forwarded one are never equal by chance.

// File: rtl/fpu_fwd_pkg.sv
package fpu_fwd_pkg;
  parameter int unsigned FW_DATA = 32;
  parameter int unsigned FW_REGS = 8;
  localparam int unsigned FW_RIDX = $clog2(FW_REGS);
  localparam int unsigned FW_STAGES = 4;
  localparam int ST_R2 = 0;
  localparam int ST_E1 = 1;
  localparam int ST_E2 = 2;
  localparam int ST_E3 = 3;
  localparam logic [FW_DATA-1:0] FW_BIAS = FW_DATA'(32'h0000_9E37);

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_SHORT = 2'd1,
    OP_LONG  = 2'd2,
    OP_MOVE  = 2'd3
  } fw_op_e;

  typedef struct packed {
    logic               vld;
    fw_op_e             op;
    logic [FW_RIDX-1:0] idx;
    logic [FW_DATA-1:0] data;   // operand until dvld, then result
    logic               dvld;
  } fw_slot_t;

  // placeholder arithmetic: 5*a + bias
  function automatic logic [FW_DATA-1:0] fw_result(input logic [FW_DATA-1:0] a);
    return (a << 2) + a + FW_BIAS;
  endfunction

  function automatic logic fw_is_prod(input fw_op_e op);
    return (op == OP_SHORT) || (op == OP_LONG);
  endfunction

  // does a producer get its result when it enters stage dst
  function automatic logic fw_ready_on_entry(input fw_op_e op, input int dst, input logic safe);
    if (dst == ST_E2) return (op == OP_SHORT) && !safe;
    if (dst == ST_E3) return fw_is_prod(op);
    return 1'b0;
  endfunction
endpackage

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fpu_fwd_pkg::*;
(
  input  fw_slot_t              slots_i [FW_STAGES],
  input  logic [FW_RIDX-1:0]    src_i,
  input  logic [FW_DATA-1:0]    rf_data_i,
  output logic [FW_DATA-1:0]    opnd_o,
  output logic                  hit_o,
  output logic                  wait_o,
  output logic [FW_STAGES-1:0]  pick_o
);
  logic [FW_STAGES-1:0] match;
  logic [FW_STAGES-1:0] ready;

  for (genvar s = 0; s < FW_STAGES; s++) begin : g_match
    assign match[s] = slots_i[s].vld && fw_is_prod(slots_i[s].op) && (slots_i[s].idx == src_i);
    assign ready[s] = slots_i[s].dvld;
  end

  // lower index = younger; scan old to young so the youngest wins
  always_comb begin
    pick_o = '0;
    for (int s = FW_STAGES - 1; s >= 0; s--) begin
      if (match[s]) begin
        pick_o    = '0;
        pick_o[s] = 1'b1;
      end
    end
  end

  always_comb begin
    opnd_o = rf_data_i;
    for (int s = 0; s < FW_STAGES; s++) begin
      if (pick_o[s]) opnd_o = slots_i[s].data;
    end
  end

  assign hit_o  = |match;
  assign wait_o = |(pick_o & ~ready);
endmodule

// File: rtl/fpu_fwd_unit.sv
module fpu_fwd_unit
  import fpu_fwd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_i,
  input  logic               safe_mode_i,
  input  logic               issue_valid_i,
  input  logic [1:0]         issue_op_i,
  input  logic [FW_RIDX-1:0] issue_idx_i,
  input  logic [FW_DATA-1:0] issue_opnd_i,
  output logic               issue_ready_o,
  output logic               mv_valid_o,
  output logic [FW_DATA-1:0] mv_data_o
);
  fw_slot_t stg_q [FW_STAGES];
  fw_slot_t stg_d [FW_STAGES];

  fw_op_e               r1_op;
  logic                 advance;
  logic                 interlock;
  logic                 accept;
  logic                 accept_move;
  logic                 retire;
  logic                 rf_we;
  logic                 fwd_hit;
  logic                 fwd_wait;
  logic [FW_DATA-1:0]   fwd_opnd;
  logic [FW_DATA-1:0]   rf_rdata;
  logic [FW_STAGES-1:0] fwd_pick;
  logic [FW_STAGES-1:0] occ;
  logic [FW_STAGES-1:0] dvld_vec;

  assign r1_op = fw_op_e'(issue_op_i);

  fwd_regfile #(.NREG(FW_REGS), .DW(FW_DATA), .IW(FW_RIDX)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (stg_q[ST_E3].idx),
    .wdata (stg_q[ST_E3].data),
    .raddr (issue_idx_i),
    .rdata (rf_rdata)
  );

  fwd_select u_sel (
    .slots_i   (stg_q),
    .src_i     (issue_idx_i),
    .rf_data_i (rf_rdata),
    .opnd_o    (fwd_opnd),
    .hit_o     (fwd_hit),
    .wait_o    (fwd_wait),
    .pick_o    (fwd_pick)
  );

  assign advance       = !stall_i;
  assign interlock     = issue_valid_i && (r1_op == OP_MOVE) && fwd_wait;
  assign issue_ready_o = advance && !interlock;
  assign accept        = issue_valid_i && issue_ready_o;
  assign accept_move   = accept && (r1_op == OP_MOVE);
  assign retire        = advance && stg_q[ST_E3].vld;
  assign rf_we         = retire && fw_is_prod(stg_q[ST_E3].op);
  assign mv_valid_o    = retire && (stg_q[ST_E3].op == OP_MOVE);
  assign mv_data_o     = stg_q[ST_E3].data;

  for (genvar s = 0; s < FW_STAGES; s++) begin : g_obs
    assign occ[s]      = stg_q[s].vld;
    assign dvld_vec[s] = stg_q[s].dvld;
  end

  always_comb begin
    stg_d[ST_R2] = '0;
    if (accept) begin
      stg_d[ST_R2].vld  = 1'b1;
      stg_d[ST_R2].op   = r1_op;
      stg_d[ST_R2].idx  = issue_idx_i;
      stg_d[ST_R2].data = (r1_op == OP_MOVE) ? fwd_opnd : issue_opnd_i;
      stg_d[ST_R2].dvld = (r1_op == OP_MOVE);
    end
    for (int s = 1; s < FW_STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
      if (stg_q[s-1].vld && !stg_q[s-1].dvld &&
          fw_ready_on_entry(stg_q[s-1].op, s, safe_mode_i)) begin
        stg_d[s].data = fw_result(stg_q[s-1].data);
        stg_d[s].dvld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < FW_STAGES; s++) stg_q[s] <= '0;
    end else if (advance) begin
      for (int s = 0; s < FW_STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end
endmodule

// File: rtl/fwd_unit_checker.sv
module fwd_unit_checker
  import fpu_fwd_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 stall_i,
  input logic                 issue_ready_o,
  input logic                 mv_valid_o,
  input logic                 interlock,
  input logic                 accept_move,
  input logic                 rf_we,
  input logic                 fwd_hit,
  input logic                 fwd_wait,
  input logic [FW_STAGES-1:0] fwd_pick,
  input logic [FW_STAGES-1:0] occ,
  input logic [FW_STAGES-1:0] dvld_vec
);
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> (occ == $past(occ)) && (dvld_vec == $past(dvld_vec)));

  p_stall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> (!issue_ready_o && !rf_we && !mv_valid_o));

  p_interlock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    interlock |-> !issue_ready_o);

  p_pick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_pick));

  p_wait_has_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_wait |-> fwd_hit);

  p_move_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_move |=> (occ[0] && dvld_vec[0]));
endmodule

bind fpu_fwd_unit fwd_unit_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall_i       (stall_i),
  .issue_ready_o (issue_ready_o),
  .mv_valid_o    (mv_valid_o),
  .interlock     (interlock),
  .accept_move   (accept_move),
  .rf_we         (rf_we),
  .fwd_hit       (fwd_hit),
  .fwd_wait      (fwd_wait),
  .fwd_pick      (fwd_pick),
  .occ           (occ),
  .dvld_vec      (dvld_vec)
);

// File: tb/tb_fpu_fwd_unit.sv
module tb_fpu_fwd_unit;
  import fpu_fwd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_i = 1'b0;
  logic        safe_mode_i = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic [1:0]  issue_op_i = '0;
  logic [2:0]  issue_idx_i = '0;
  logic [31:0] issue_opnd_i = '0;
  logic        issue_ready_o;
  logic        mv_valid_o;
  logic [31:0] mv_data_o;

  always #5 clk = ~clk;

  fpu_fwd_unit dut (.*);

  int checks = 0;
  int fails = 0;
  int stall_pct = 0;
  int force_stall = 0;
  int moves_sent = 0;
  int moves_seen = 0;
  string val_tag = "R1";
  logic [31:0] ref_rf [8];
  logic [31:0] exp_q [$];

  function automatic logic [31:0] ref_fn(input logic [31:0] x);
    return x * 32'd5 + 32'd40503;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_stall();
    if (force_stall > 0) begin
      stall_i = 1'b1;
      force_stall--;
    end else begin
      stall_i = ($urandom_range(99) < stall_pct);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic send(input int op, input int idx, input logic [31:0] d, output int waits);
    waits = 0;
    issue_valid_i = 1'b1;
    issue_op_i = op[1:0];
    issue_idx_i = idx[2:0];
    issue_opnd_i = d;
    forever begin
      set_stall();
      #1;
      if (issue_ready_o) begin
        if (op == 3) begin
          exp_q.push_back(ref_rf[idx]);
          moves_sent++;
        end else if (op == 1 || op == 2) begin
          ref_rf[idx] = ref_fn(d);
        end
        @(negedge clk);
        break;
      end
      waits++;
      @(negedge clk);
    end
    issue_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      set_stall();
      issue_valid_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    stall_pct = 0;
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) idle(1);
    idle(6);
    check(exp_q.size() == 0, "R2", "moves still outstanding", exp_q.size(), 0);
  endtask

  // output monitor, samples 1 ns before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rst_n && mv_valid_o) begin
        moves_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected move output", mv_data_o, 0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(mv_data_o == e, val_tag, "move value", mv_data_o, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) ref_rf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(issue_ready_o == 1'b1, "R1", "ready after reset", issue_ready_o, 1);
    check(mv_valid_o == 1'b0, "R1", "no move after reset", mv_valid_o, 0);
    @(negedge clk);
    val_tag = "R1";
    send(3, 0, 0, w);
    send(3, 7, 0, w);
    drain();

    // R4: short then dependent move
    val_tag = "R4";
    send(1, 1, 32'h1234_5678, w);
    send(3, 1, 0, w);
    check(w == 2, "R4", "waits after short producer", w, 2);
    drain();
    // R4: long then dependent move
    send(2, 2, 32'hFFFF_FFF0, w);
    send(3, 2, 0, w);
    check(w == 3, "R4", "waits after long producer", w, 3);
    drain();
    // R4: one unrelated instruction in between
    send(1, 3, 32'hCAFE_0001, w);
    send(0, 0, 0, w);
    send(3, 3, 0, w);
    check(w == 1, "R4", "waits with one gap", w, 1);
    drain();

    // R7: independent move
    val_tag = "R7";
    send(1, 1, 32'h0BAD_F00D, w);
    send(3, 5, 0, w);
    check(w == 0, "R7", "independent move waits", w, 0);
    drain();

    // R3: youngest of two producers wins
    val_tag = "R3";
    send(1, 4, 32'h1111_1111, w);
    send(1, 4, 32'h2222_2222, w);
    send(3, 4, 0, w);
    check(w == 2, "R3", "waits behind younger producer", w, 2);
    drain();
    // R3: long older, short younger to same register, gap so both have data
    send(2, 4, 32'h3333_3333, w);
    send(1, 4, 32'h4444_4444, w);
    send(0, 0, 0, w);
    send(0, 0, 0, w);
    send(3, 4, 0, w);
    drain();

    // R5: producer frozen in E3 while the move waits in R1
    val_tag = "R5";
    send(2, 6, 32'hDEAD_BEEF, w);
    send(0, 0, 0, w);
    send(0, 0, 0, w);
    send(0, 0, 0, w);
    force_stall = 4;
    send(3, 6, 0, w);
    check(w == 4, "R5", "move held during stall", w, 4);
    drain();
    // R5: stall right after a move is accepted delays nothing but timing
    send(1, 0, 32'h0F0F_0F0F, w);
    send(3, 0, 0, w);
    force_stall = 5;
    idle(5);
    check(moves_seen == moves_sent - 1, "R5", "no retire while stalled", moves_seen, moves_sent - 1);
    drain();

    // R6: conservative mode
    val_tag = "R6";
    safe_mode_i = 1'b1;
    send(1, 1, 32'h5555_AAAA, w);
    send(3, 1, 0, w);
    check(w == 3, "R6", "safe mode waits after short", w, 3);
    drain();
    send(1, 2, 32'h7777_0000, w);
    send(0, 0, 0, w);
    send(0, 0, 0, w);
    send(0, 0, 0, w);
    send(3, 2, 0, w);
    check(w == 0, "R6", "safe mode three gaps", w, 0);
    drain();

    // R9 / R8: random streams under random stalls, both modes
    val_tag = "R9";
    for (int mode = 0; mode < 2; mode++) begin
      safe_mode_i = mode[0];
      stall_pct = 25;
      for (int n = 0; n < 400; n++) begin
        send($urandom_range(3), $urandom_range(7), $urandom, w);
      end
      drain();
      check(moves_seen == moves_sent, "R9", "move count", moves_seen, moves_sent);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule